// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table held in ordinary memory. A request carries the virtual address, the kind of access (read or write, user or supervisor) and the frame number of the top-level table. The walker then fetches the top-level entry and, unless that entry maps a 4 MB page directly, the second-level entry. It checks the entries and signals completion with a single-cycle pulse that carries either the physical address or a fault cause.

On a successful walk the walker records use in memory. Every entry it passed through gets its accessed flag set. The final entry also gets its dirty flag set when the access was a write. An entry is written back only when this changes its value. Memory is reached through a plain word port: one request at a time, each acknowledged by the memory, with read data returned alongside the acknowledge.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read from the word address formed by root_frame in bits 31:12, virtual address bits 31:22 in bits 11:2, and zero in bits 1:0.
- R2: When the top-level entry has bit 7 clear, the second-level entry is read from the address formed by that entry's bits 31:12, virtual address bits 21:12 and two zero bits. The physical address is then second-level entry bits 31:12 joined with virtual address bits 11:0.
- R3: When the top-level entry has bit 7 set, no second-level read is issued. The physical address is top-level entry bits 31:22 joined with virtual address bits 21:0.
- R4: An entry on the path with bit 0 (present) clear ends the walk with done_fault high and cause 1. This applies at either level.
- R5: Every entry on the path is checked. A user access (req_user=1) through an entry with bit 2 clear faults with cause 2. A write (req_write=1) through an entry with bit 1 clear faults with cause 3. A not-present entry takes priority over a user fault, and a user fault takes priority over a write fault.
- R6: After a successful walk, every entry used has bit 5 (accessed) set in memory. The final entry also has bit 6 (dirty) set if the access was a write. A top-level entry that points to a second-level table never gets bit 6 set by the walker.
- R7: An entry is written back only if its updated value differs from the value read. The top-level entry is written before the second-level entry. A faulting walk writes nothing.
- R8: mem_req is high for one cycle per access. No new access is issued until mem_ack has answered the previous one.
- R9: A request is taken only while req_ready is high. A req_valid pulse during a walk starts nothing and produces no extra done pulse.
- R10: After reset, req_ready is 1, and done and mem_req are 0. Each walk gives exactly one done pulse, in the cycle req_ready returns high. done_cause is 0 when done_fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_frame | input | 20 | Frame number of the top-level table |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Memory answers the pending access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | Walk finished (one cycle) |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 not present, 2 user, 3 write |
| done_paddr | output | 32 | Physical address on success, else 0 |

## Verification
Random tables are built in a bench memory. About one top-level entry in four maps a large page, and present, user and write flags are mostly set but sometimes clear. Random addresses and access kinds then sweep small-page hits, large-page hits and faults at both levels against a reference walk, with random memory latency.

Directed cases separate the fault causes where more than one flag is bad, which exposes the priority order. A repeated walk over entries that are already marked must produce no writes. A walk with a request pulsed while busy must still end in a single completion and issue no further accesses afterwards.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACC     = 5;
  localparam int BIT_DIRTY   = 6;
  localparam int BIT_BIG     = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_USER   = 2'd2,
    CAUSE_WRITE  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_RD2, ST_WB1, ST_WB2
  } state_e;
endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  input  logic             is_leaf,
  output logic             fault,
  output logic [1:0]       cause,
  output logic [ENT_W-1:0] updated,
  output logic             changed
);
  cause_e c;

  always_comb begin
    c = CAUSE_NONE;
    if (!entry[BIT_PRESENT])             c = CAUSE_ABSENT;
    else if (is_user && !entry[BIT_USER]) c = CAUSE_USER;
    else if (is_write && !entry[BIT_WRITE]) c = CAUSE_WRITE;
  end

  always_comb begin
    updated = entry;
    updated[BIT_ACC] = 1'b1;
    if (is_leaf && is_write) updated[BIT_DIRTY] = 1'b1;
  end

  assign cause   = c;
  assign fault   = (c != CAUSE_NONE);
  assign changed = (updated != entry);
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int ENT_W     = 32,
  parameter int IDX_W     = 10,
  parameter int FRAME_LSB = 12
) (
  input  logic [ENT_W-FRAME_LSB-1:0] frame,
  input  logic [IDX_W-1:0]           idx,
  output logic [ENT_W-1:0]           addr
);
  localparam int PAD_W = FRAME_LSB - IDX_W;

  assign addr = {frame, idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int IDX1_W = 10,
  parameter int IDX2_W = 10,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX1_W+IDX2_W+OFF_W-1:0] req_vaddr,
  input  logic                   req_write,
  input  logic                   req_user,
  input  logic [ENT_W-OFF_W-1:0] root_frame,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ENT_W-1:0]       mem_addr,
  output logic [ENT_W-1:0]       mem_wdata,
  input  logic                   mem_ack,
  input  logic [ENT_W-1:0]       mem_rdata,
  output logic                   done,
  output logic                   done_fault,
  output logic [1:0]             done_cause,
  output logic [ENT_W-1:0]       done_paddr
);
  localparam int VA_W      = IDX1_W + IDX2_W + OFF_W;
  localparam int BIG_OFF_W = IDX2_W + OFF_W;

  state_e               state_q;
  logic [BIG_OFF_W-1:0] va_q;
  logic                 wr_q, us_q, big_q, e2_chg_q;
  logic [ENT_W-1:0]     e1_q, e1_new_q, e1_addr_q;
  logic [ENT_W-1:0]     e2_new_q, e2_addr_q, pa_q;

  logic [ENT_W-1:0] l1_addr, l2_addr, leaf_pa, chk_upd;
  logic             chk_fault, chk_changed, chk_leaf;
  logic [1:0]       chk_cause;

  pt_addr_gen #(.ENT_W(ENT_W), .IDX_W(IDX1_W), .FRAME_LSB(OFF_W)) u_l1_addr (
    .frame(root_frame),
    .idx  (req_vaddr[VA_W-1 -: IDX1_W]),
    .addr (l1_addr)
  );

  pt_addr_gen #(.ENT_W(ENT_W), .IDX_W(IDX2_W), .FRAME_LSB(OFF_W)) u_l2_addr (
    .frame(mem_rdata[ENT_W-1:OFF_W]),
    .idx  (va_q[OFF_W +: IDX2_W]),
    .addr (l2_addr)
  );

  assign chk_leaf = (state_q == ST_RD2) || mem_rdata[BIT_BIG];

  pt_entry_check #(.ENT_W(ENT_W)) u_check (
    .entry   (mem_rdata),
    .is_write(wr_q),
    .is_user (us_q),
    .is_leaf (chk_leaf),
    .fault   (chk_fault),
    .cause   (chk_cause),
    .updated (chk_upd),
    .changed (chk_changed)
  );

  always_comb begin
    if (state_q == ST_RD1)
      leaf_pa = {mem_rdata[ENT_W-1:BIG_OFF_W], va_q[BIG_OFF_W-1:0]};
    else
      leaf_pa = {mem_rdata[ENT_W-1:OFF_W], va_q[OFF_W-1:0]};
  end

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      big_q      <= 1'b0;
      e2_chg_q   <= 1'b0;
      e1_q       <= '0;
      e1_new_q   <= '0;
      e1_addr_q  <= '0;
      e2_new_q   <= '0;
      e2_addr_q  <= '0;
      pa_q       <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      done_fault <= 1'b0;
      done_cause <= 2'd0;
      done_paddr <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr[BIG_OFF_W-1:0];
            wr_q      <= req_write;
            us_q      <= req_user;
            e1_addr_q <= l1_addr;
            mem_addr  <= l1_addr;
            mem_we    <= 1'b0;
            mem_req   <= 1'b1;
            state_q   <= ST_RD1;
          end
        end
        ST_RD1: begin
          if (mem_ack) begin
            e1_q     <= mem_rdata;
            e1_new_q <= chk_upd;
            big_q    <= mem_rdata[BIT_BIG];
            if (chk_fault) begin
              done       <= 1'b1;
              done_fault <= 1'b1;
              done_cause <= chk_cause;
              done_paddr <= '0;
              state_q    <= ST_IDLE;
            end else if (mem_rdata[BIT_BIG]) begin
              pa_q <= leaf_pa;
              if (chk_changed) begin
                mem_addr  <= e1_addr_q;
                mem_wdata <= chk_upd;
                mem_we    <= 1'b1;
                mem_req   <= 1'b1;
                state_q   <= ST_WB1;
              end else begin
                done       <= 1'b1;
                done_fault <= 1'b0;
                done_cause <= 2'd0;
                done_paddr <= leaf_pa;
                state_q    <= ST_IDLE;
              end
            end else begin
              e2_addr_q <= l2_addr;
              mem_addr  <= l2_addr;
              mem_we    <= 1'b0;
              mem_req   <= 1'b1;
              state_q   <= ST_RD2;
            end
          end
        end
        ST_RD2: begin
          if (mem_ack) begin
            if (chk_fault) begin
              done       <= 1'b1;
              done_fault <= 1'b1;
              done_cause <= chk_cause;
              done_paddr <= '0;
              state_q    <= ST_IDLE;
            end else begin
              e2_new_q <= chk_upd;
              e2_chg_q <= chk_changed;
              pa_q     <= leaf_pa;
              if (e1_new_q != e1_q) begin
                mem_addr  <= e1_addr_q;
                mem_wdata <= e1_new_q;
                mem_we    <= 1'b1;
                mem_req   <= 1'b1;
                state_q   <= ST_WB1;
              end else if (chk_changed) begin
                mem_addr  <= e2_addr_q;
                mem_wdata <= chk_upd;
                mem_we    <= 1'b1;
                mem_req   <= 1'b1;
                state_q   <= ST_WB2;
              end else begin
                done       <= 1'b1;
                done_fault <= 1'b0;
                done_cause <= 2'd0;
                done_paddr <= leaf_pa;
                state_q    <= ST_IDLE;
              end
            end
          end
        end
        ST_WB1: begin
          if (mem_ack) begin
            if (!big_q && e2_chg_q) begin
              mem_addr  <= e2_addr_q;
              mem_wdata <= e2_new_q;
              mem_we    <= 1'b1;
              mem_req   <= 1'b1;
              state_q   <= ST_WB2;
            end else begin
              done       <= 1'b1;
              done_fault <= 1'b0;
              done_cause <= 2'd0;
              done_paddr <= pa_q;
              state_q    <= ST_IDLE;
            end
          end
        end
        ST_WB2: begin
          if (mem_ack) begin
            done       <= 1'b1;
            done_fault <= 1'b0;
            done_cause <= 2'd0;
            done_paddr <= pa_q;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       mem_req,
  input logic       mem_we,
  input logic       wb_acc,
  input logic       mem_ack,
  input logic       done,
  input logic       done_fault,
  input logic [1:0] done_cause
);
  logic outst;

  always_ff @(posedge clk) begin
    if (rst)          outst <= 1'b0;
    else if (mem_req) outst <= 1'b1;
    else if (mem_ack) outst <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) mem_req |-> !outst); // R8
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R8
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) mem_req |-> !req_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> req_ready); // R10
  AST_OK_CAUSE: assert property (@(posedge clk) disable iff (rst) (done && !done_fault) |-> (done_cause == 2'd0)); // R10
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst) (done && done_fault) |-> (done_cause != 2'd0)); // R4
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (rst) (mem_req && mem_we) |-> wb_acc); // R6
endmodule

bind pt_walker pt_walker_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .wb_acc    (mem_wdata[5]),
  .mem_ack   (mem_ack),
  .done      (done),
  .done_fault(done_fault),
  .done_cause(done_cause)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] root_frame = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, done_fault;
  logic [1:0]  done_cause;
  logic [31:0] done_paddr;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .root_frame(root_frame), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .done_fault(done_fault),
    .done_cause(done_cause), .done_paddr(done_paddr)
  );

  logic [31:0] bmem [0:4095];
  logic [31:0] wa [0:7];
  logic [31:0] hold;
  int unsigned checks = 0, errors = 0;
  int unsigned req_cnt = 0, done_cnt = 0, walk_wr = 0, lat = 0;
  logic        got_fault;
  logic [1:0]  got_cause;
  logic [31:0] got_pa;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model, sampled and driven at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = bmem[hold[13:2]];
        end
      end
      if (!rst && mem_req) begin
        hold = mem_addr;
        req_cnt++;
        if (mem_we) begin
          bmem[mem_addr[13:2]] = mem_wdata;
          if (walk_wr < 8) wa[walk_wr] = mem_addr;
          walk_wr++;
        end
        lat = 1 + ($urandom % 3);
      end
      if (!rst && done) begin
        done_cnt++;
        got_fault = done_fault;
        got_cause = done_cause;
        got_pa    = done_paddr;
      end
    end
  end

  task automatic ref_walk(input logic [31:0] va, input bit wr, input bit us,
                          input logic [19:0] root,
                          output bit f, output logic [1:0] c, output logic [31:0] pa,
                          output int nw, output logic [31:0] a1, output logic [31:0] n1,
                          output bit h2, output logic [31:0] a2, output logic [31:0] n2);
    logic [31:0] e1, e2;
    a1 = {root, va[31:22], 2'b00};
    e1 = bmem[a1[13:2]];
    c = 2'd0; f = 0; pa = '0; nw = 0; h2 = 0; a2 = '0; n1 = e1; n2 = '0;
    if (!e1[0]) c = 2'd1;
    else if (us && !e1[2]) c = 2'd2;
    else if (wr && !e1[1]) c = 2'd3;
    if (c != 0) begin f = 1; return; end
    if (e1[7]) begin
      n1 = e1 | 32'h20 | (wr ? 32'h40 : 32'h0);
      pa = {e1[31:22], va[21:0]};
      nw = (n1 != e1) ? 1 : 0;
      return;
    end
    h2 = 1;
    a2 = {e1[31:12], va[21:12], 2'b00};
    e2 = bmem[a2[13:2]];
    n2 = e2;
    if (!e2[0]) c = 2'd1;
    else if (us && !e2[2]) c = 2'd2;
    else if (wr && !e2[1]) c = 2'd3;
    if (c != 0) begin f = 1; return; end
    n1 = e1 | 32'h20;
    n2 = e2 | 32'h20 | (wr ? 32'h40 : 32'h0);
    pa = {e2[31:12], va[11:0]};
    nw = ((n1 != e1) ? 1 : 0) + ((n2 != e2) ? 1 : 0);
  endtask

  task automatic do_walk(input logic [31:0] va, input bit wr, input bit us,
                         input bit poke, input string tag);
    bit f, h2;
    logic [1:0] c;
    logic [31:0] pa, a1, n1, a2, n2;
    int nw;
    int unsigned d0, r0, n;
    ref_walk(va, wr, us, root_frame, f, c, pa, nw, a1, n1, h2, a2, n2);
    walk_wr = 0;
    d0 = done_cnt;
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      chk(req_ready == 1'b0, "R9", "ready low during walk", {31'd0, req_ready}, 32'd0);
      req_vaddr = ~va; req_write = ~wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (done_cnt == d0 && n < 500) begin @(posedge clk); n++; end
    @(negedge clk);
    if (done_cnt == d0) begin
      chk(1'b0, tag, "walk timeout", 32'd0, 32'd1);
      return;
    end
    chk(got_fault == f, (f ? "R4" : tag), "fault flag", {31'd0, got_fault}, {31'd0, f});
    chk(got_cause == c, (c == 2'd1 ? "R4" : "R5"), "cause", {30'd0, got_cause}, {30'd0, c});
    if (!f) chk(got_pa == pa, tag, "physical address", got_pa, pa);
    chk(walk_wr == nw, "R7", "write count", walk_wr, nw);
    chk(bmem[a1[13:2]] == n1, "R6", "top entry after walk", bmem[a1[13:2]], n1);
    if (h2) chk(bmem[a2[13:2]] == n2, "R6", "second entry after walk", bmem[a2[13:2]], n2);
    if (nw > 0 && n1 != bmem[a1[13:2]] ^ 32'd0 && 0) ;
    if (nw == 2) chk(wa[0] == a1, "R7", "top entry written first", wa[0], a1);
    if (poke) begin
      r0 = req_cnt;
      repeat (10) @(negedge clk);
      chk(done_cnt == d0 + 1, "R9", "single done pulse", done_cnt - d0, 32'd1);
      chk(req_cnt == r0, "R9", "no access after done", req_cnt - r0, 32'd0);
    end
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 1024; i++) begin
      e = $urandom;
      e[0] = ($urandom % 8) != 0;
      e[1] = ($urandom % 4) != 0;
      e[2] = ($urandom % 4) != 0;
      e[7] = ($urandom % 4) == 0;
      if (!e[7]) e[31:12] = 20'd1 + 20'($urandom % 3);
      bmem[i] = e;
    end
    for (int i = 1024; i < 4096; i++) begin
      e = $urandom;
      e[0] = ($urandom % 8) != 0;
      e[1] = ($urandom % 4) != 0;
      e[2] = ($urandom % 4) != 0;
      bmem[i] = e;
    end
    root_frame = 20'd0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", {31'd0, req_ready}, 32'd1);
    chk(done == 1'b0, "R10", "done after reset", {31'd0, done}, 32'd0);
    chk(mem_req == 1'b0, "R10", "no access after reset", {31'd0, mem_req}, 32'd0);

    // R4: top-level entry absent
    bmem[5] = 32'h0000_1006;
    do_walk({10'd5, 10'd3, 12'h111}, 1'b0, 1'b0, 1'b0, "R4");
    chk(got_cause == 2'd1, "R4", "top absent cause", {30'd0, got_cause}, 32'd1);

    // R4: second-level entry absent
    bmem[6] = 32'h0000_1007;
    bmem[1024 + 7] = 32'hABCD_E006;
    do_walk({10'd6, 10'd7, 12'h222}, 1'b1, 1'b1, 1'b0, "R4");
    chk(got_cause == 2'd1, "R4", "second absent cause", {30'd0, got_cause}, 32'd1);

    // R5: user and write both bad -> user wins
    bmem[1024 + 8] = 32'h1234_5001;
    do_walk({10'd6, 10'd8, 12'h333}, 1'b1, 1'b1, 1'b0, "R5");
    chk(got_cause == 2'd2, "R5", "user priority", {30'd0, got_cause}, 32'd2);

    // R5: supervisor write to read-only entry
    bmem[1024 + 9] = 32'h1234_6005;
    do_walk({10'd6, 10'd9, 12'h444}, 1'b1, 1'b0, 1'b0, "R5");
    chk(got_cause == 2'd3, "R5", "write protect", {30'd0, got_cause}, 32'd3);

    // R3: large page write, second read skipped
    bmem[8] = 32'hABC0_0087;
    do_walk({10'd8, 10'h155, 12'h5A5}, 1'b1, 1'b1, 1'b0, "R3");
    chk(got_pa == 32'hABD5_55A5, "R3", "large page address", got_pa, 32'hABD5_55A5);
    chk(bmem[8] == 32'hABC0_00E7, "R6", "large page marks", bmem[8], 32'hABC0_00E7);

    // R2/R6: small page read, both entries marked accessed, no dirty
    bmem[9] = 32'h0000_2007;
    bmem[2048 + 10] = 32'h7654_3007;
    do_walk({10'd9, 10'd10, 12'h0F0}, 1'b0, 1'b1, 1'b0, "R2");
    chk(got_pa == 32'h7654_30F0, "R2", "small page address", got_pa, 32'h7654_30F0);
    chk(bmem[2048 + 10] == 32'h7654_3027, "R6", "leaf accessed only", bmem[2048 + 10], 32'h7654_3027);
    chk(bmem[9] == 32'h0000_2027, "R6", "directory accessed", bmem[9], 32'h0000_2027);

    // R7: repeat, nothing changes
    do_walk({10'd9, 10'd10, 12'h0F0}, 1'b0, 1'b1, 1'b0, "R7");
    chk(walk_wr == 0, "R7", "no rewrite", walk_wr, 32'd0);

    // R6: write marks leaf dirty, directory stays clean
    do_walk({10'd9, 10'd10, 12'h00C}, 1'b1, 1'b0, 1'b0, "R6");
    chk(bmem[2048 + 10] == 32'h7654_3067, "R6", "leaf dirty", bmem[2048 + 10], 32'h7654_3067);
    chk(bmem[9][6] == 1'b0, "R6", "directory not dirty", {31'd0, bmem[9][6]}, 32'd0);

    // R1: nonzero root frame
    root_frame = 20'd3;
    do_walk({10'd17, 10'd4, 12'hABC}, 1'b0, 1'b0, 1'b0, "R1");
    root_frame = 20'd0;

    // R9: request while busy
    bmem[12] = 32'h0000_3007;
    bmem[3072 + 2] = 32'h0F0F_0005;
    do_walk({10'd12, 10'd2, 12'h777}, 1'b0, 1'b0, 1'b1, "R9");

    // random walks
    for (int k = 0; k < 400; k++) begin
      do_walk($urandom, 1'($urandom), 1'($urandom), (k % 37) == 0, "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule